// File: doc/BRIEF.md
# SCSI Initiator Input Handshake Engine

This block receives a run of bytes from a SCSI target while acting as the initiator on the asynchronous REQ/ACK handshake. Software or a controller loads a byte count and pulses `start`. The engine then answers each target request with ACK and captures the bus byte into a staging register at that moment. It moves each byte into a host-facing data register, and a DMA agent empties that register through a DREQ/DACK pair.

There are two data registers, each with its own full flag, so that one byte can sit in staging while the DMA agent has not yet collected the previous one. A transfer counter counts down once per accepted byte. It is decremented when REQ is accepted, before the byte moves on. When the counter reaches zero the engine finishes the current byte and stops handshaking. It reports completion with a one-cycle `func_done` pulse, and only once the final byte has been collected from the host register. REQ comes from the cable and is synchronized before use. ACK comes straight from a flop.

Top module: `scsi_in_engine`

## Requirements
- R1: After reset, `scsi_ack_out`, `dma_dreq`, `busy`, `func_done`, `host_full` and `stage_full` are 0 and `xfer_left` is 0.
- R2: ACK is raised only after the synchronized REQ has been seen high while the engine is waiting for a request. The bus byte is captured into the staging register in that same cycle, and bytes reach `dma_data` in bus order.
- R3: ACK falls only after the synchronized REQ is low. A new ACK needs both a falling ACK and a fresh REQ, so a target that holds REQ high for a long time after ACK still delivers exactly one byte.
- R4: `xfer_left` is loaded from `xfer_len` on an accepted `start`. It decreases by one in the cycle ACK rises and never changes at any other time during a transfer.
- R5: A byte moves from staging into the host register only when the host register is empty. `dma_dreq` is high exactly while the host register holds a byte. A one-cycle `dma_dack` empties the host register, and a `dma_dack` while the host register is empty has no effect.
- R6: `stage_full` and `host_full` report the two registers separately. While the staging register is full, no new ACK is raised even if REQ is high.
- R7: A transfer of N bytes produces exactly N rising edges of `dma_dreq`, and none after the last byte.
- R8: `func_done` is a single-cycle pulse. It appears only after the final byte has been taken by DACK and ACK is low, and `busy` is 0 from that cycle on. While the final byte is still waiting in the host register, `busy` stays 1.
- R9: A `start` with `xfer_len` = 0 raises no ACK and no DREQ. It yields `func_done` two clock edges after `start` is sampled.
- R10: A `start` pulse while `busy` is 1 is ignored, and `xfer_left` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer of `xfer_len` bytes (taken only when idle) |
| xfer_len | input | CNT_W | Number of bytes to receive |
| scsi_req_in | input | 1 | REQ from the target, asynchronous |
| scsi_data_in | input | DATA_W | SCSI data bus |
| scsi_ack_out | output | 1 | ACK to the target, registered |
| dma_dreq | output | 1 | DMA request: host register holds a byte |
| dma_dack | input | 1 | DMA acknowledge: one-cycle pulse pops the host register |
| dma_data | output | DATA_W | Host register contents |
| host_full | output | 1 | Host-facing register holds a byte |
| stage_full | output | 1 | Staging register holds a byte not yet moved |
| xfer_left | output | CNT_W | Bytes still to be accepted |
| busy | output | 1 | Transfer in progress |
| func_done | output | 1 | One-cycle pulse when the transfer has fully left the engine |

## Verification
The bound checker watches the handshake ordering on every cycle. It checks that ACK rises only on a seen REQ and falls only on a released REQ, that the counter moves only together with a new ACK, that nothing is captured into an occupied staging register, and that completion coincides with an idle, quiet interface. Other properties need whole scenarios and are shown only by the bench: byte order through both registers, the exact count of DREQ pulses, the stall when both registers are full, the suppression of a second byte when a slow target holds REQ, zero-length and busy-time starts, and the delay of completion until the DMA agent collects the last byte.

// File: rtl/scsi_in_pkg.sv
package scsi_in_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WREQ  = 3'd1,
        ST_REL   = 3'd2,
        ST_MOVE  = 3'd3,
        ST_WACK  = 3'd4,
        ST_DRAIN = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic stage_full;
        logic host_full;
    } buf_flags_t;

    typedef struct packed {
        logic accept;
        logic move;
        logic load;
    } seq_cmd_t;

    function automatic logic ack_next(input logic accept, input logic drop_en,
                                      input logic req_s, input logic ack_cur);
        logic n;
        n = ack_cur;
        if (accept)
            n = 1'b1;
        else if (drop_en && !req_s)
            n = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/scsi_in_req_sync.sv
module scsi_in_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/scsi_in_xfer_ctr.sv
module scsi_in_xfer_ctr #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] left,
    output logic             at_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load)
            left <= load_val;
        else if (dec && left != '0)
            left <= left - ONE;
    end

    assign at_one = (left == ONE);
endmodule

// File: rtl/scsi_in_buffer.sv
module scsi_in_buffer
    import scsi_in_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              move,
    input  logic              pop,
    output logic [DATA_W-1:0] host_data,
    output buf_flags_t        flags
);
    logic [DATA_W-1:0] stage_q;
    buf_flags_t        flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= '0;
            host_data <= '0;
            flags_q   <= '0;
        end else begin
            if (capture) begin
                stage_q            <= bus_data;
                flags_q.stage_full <= 1'b1;
            end else if (move) begin
                flags_q.stage_full <= 1'b0;
            end

            if (move) begin
                host_data         <= stage_q;
                flags_q.host_full <= 1'b1;
            end else if (pop && flags_q.host_full) begin
                flags_q.host_full <= 1'b0;
            end
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/scsi_in_seq.sv
module scsi_in_seq
    import scsi_in_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             req_s,
    input  logic             ctr_at_one,
    input  buf_flags_t       flags,
    output seq_cmd_t         cmd,
    output logic             ack,
    output logic             busy,
    output logic             done
);
    seq_state_t state_q, state_d;
    logic       drop_en_q;
    logic       exit_q;

    always_comb begin
        state_d = state_q;
        cmd     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cmd.load = 1'b1;
                    state_d  = (len == '0) ? ST_DRAIN : ST_WREQ;
                end
            end
            ST_WREQ: begin
                if (req_s && !ack && !flags.stage_full) begin
                    cmd.accept = 1'b1;
                    state_d    = ST_REL;
                end
            end
            ST_REL:  state_d = ST_MOVE;
            ST_MOVE: begin
                if (!flags.host_full) begin
                    cmd.move = 1'b1;
                    state_d  = ST_WACK;
                end
            end
            ST_WACK: begin
                if (!ack)
                    state_d = exit_q ? ST_DRAIN : ST_WREQ;
            end
            ST_DRAIN: begin
                if (!flags.host_full)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            drop_en_q <= 1'b0;
            exit_q    <= 1'b0;
            ack       <= 1'b0;
            done      <= 1'b0;
        end else begin
            state_q <= state_d;
            ack     <= ack_next(cmd.accept, drop_en_q, req_s, ack);
            done    <= (state_q == ST_DRAIN) && !flags.host_full;

            if (state_q == ST_IDLE)
                exit_q <= 1'b0;
            else if (cmd.accept)
                exit_q <= ctr_at_one;

            if (cmd.accept || state_q == ST_IDLE)
                drop_en_q <= 1'b0;
            else if (state_q == ST_REL)
                drop_en_q <= 1'b1;
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/scsi_in_engine.sv
module scsi_in_engine
    import scsi_in_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  xfer_len,
    input  logic              scsi_req_in,
    input  logic [DATA_W-1:0] scsi_data_in,
    output logic              scsi_ack_out,
    output logic              dma_dreq,
    input  logic              dma_dack,
    output logic [DATA_W-1:0] dma_data,
    output logic              host_full,
    output logic              stage_full,
    output logic [CNT_W-1:0]  xfer_left,
    output logic              busy,
    output logic              func_done
);
    logic       req_s;
    logic       ctr_at_one;
    seq_cmd_t   cmd;
    buf_flags_t flags;

    scsi_in_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (scsi_req_in),
        .sync_out (req_s)
    );

    scsi_in_xfer_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load),
        .load_val (xfer_len),
        .dec      (cmd.accept),
        .left     (xfer_left),
        .at_one   (ctr_at_one)
    );

    scsi_in_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .capture   (cmd.accept),
        .bus_data  (scsi_data_in),
        .move      (cmd.move),
        .pop       (dma_dack),
        .host_data (dma_data),
        .flags     (flags)
    );

    scsi_in_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .len        (xfer_len),
        .req_s      (req_s),
        .ctr_at_one (ctr_at_one),
        .flags      (flags),
        .cmd        (cmd),
        .ack        (scsi_ack_out),
        .busy       (busy),
        .done       (func_done)
    );

    assign host_full  = flags.host_full;
    assign stage_full = flags.stage_full;
    assign dma_dreq   = flags.host_full;
endmodule

// File: rtl/scsi_in_engine_chk.sv
module scsi_in_engine_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             req_s,
    input logic             ack,
    input logic             dreq,
    input logic             stage_full,
    input logic [CNT_W-1:0] left,
    input logic             busy,
    input logic             done
);
    // R2: ACK rises only on a synchronized REQ
    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req_s));

    // R3: ACK falls only after REQ has been released
    a_r3_ack_drop_after_req: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !$past(req_s));

    // R4: counter moves during a transfer only together with a new ACK
    a_r4_count_on_ack: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy && left != $past(left)) |-> $rose(ack));

    // R6: no capture into an occupied staging register
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> !$past(stage_full));

    // R8: completion only with a quiet interface
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !ack && !dreq && left == '0));

    // R8: single-cycle completion pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind scsi_in_engine scsi_in_engine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_s      (req_s),
    .ack        (scsi_ack_out),
    .dreq       (dma_dreq),
    .stage_full (stage_full),
    .left       (xfer_left),
    .busy       (busy),
    .done       (func_done)
);

// File: tb/scsi_in_engine_test.sv
module scsi_in_engine_test;
    localparam int DW = 8;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] xfer_len = '0;
    logic          scsi_req_in = 1'b0;
    logic [DW-1:0] scsi_data_in = '0;
    logic          scsi_ack_out;
    logic          dma_dreq;
    logic          dma_dack = 1'b0;
    logic [DW-1:0] dma_data;
    logic          host_full, stage_full, busy, func_done;
    logic [CW-1:0] xfer_left;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int done_cnt = 0;
    int dreq_rises = 0;
    logic dreq_prev = 1'b0;

    scsi_in_engine #(.DATA_W(DW), .CNT_W(CW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .start(start), .xfer_len(xfer_len),
        .scsi_req_in(scsi_req_in), .scsi_data_in(scsi_data_in),
        .scsi_ack_out(scsi_ack_out), .dma_dreq(dma_dreq), .dma_dack(dma_dack),
        .dma_data(dma_data), .host_full(host_full), .stage_full(stage_full),
        .xfer_left(xfer_left), .busy(busy), .func_done(func_done)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (func_done) done_cnt <= done_cnt + 1;
        if (dma_dreq && !dreq_prev) dreq_rises <= dreq_rises + 1;
        dreq_prev <= dma_dreq;
        if (cyc > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int base, input int i);
        return DW'((base + i * 37) ^ 8'h5a);
    endfunction

    // vector table: length, DMA wait, REQ hold after ACK, data base
    localparam int NV = 5;
    localparam int V_LEN [NV] = '{1, 4, 6, 5, 8};
    localparam int V_DMAW[NV] = '{0, 0, 3, 0, 7};
    localparam int V_HOLD[NV] = '{0, 0, 0, 40, 2};
    localparam int V_BASE[NV] = '{17, 66, 129, 200, 3};

    task automatic pulse_start(input int n);
        @(negedge clk);
        xfer_len = CW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_ack(input logic lvl);
        for (int k = 0; k < 200 && scsi_ack_out != lvl; k++) @(negedge clk);
    endtask

    task automatic target_send(input int n, input int hold, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            scsi_data_in = pat(base, i);
            scsi_req_in = 1'b1;
            wait_ack(1'b1);
            repeat (hold) @(negedge clk);
            scsi_req_in = 1'b0;
            wait_ack(1'b0);
        end
    endtask

    task automatic dma_take(input int n, input int dw, input int base);
        int got = 0;
        for (int k = 0; k < 5000 && got < n; k++) begin
            @(negedge clk);
            if (dma_dreq) begin
                repeat (dw) @(negedge clk);
                chk(dma_data == pat(base, got), "R2 byte order", dma_data, pat(base, got));
                dma_dack = 1'b1;
                @(negedge clk);
                dma_dack = 1'b0;
                got++;
            end
        end
        chk(got == n, "R5 bytes taken", got, n);
    endtask

    task automatic wait_done();
        for (int k = 0; k < 500 && done_cnt == 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!scsi_ack_out && !dma_dreq && !busy && !func_done, "R1 outputs idle", 0, 0);
        chk(!host_full && !stage_full && xfer_left == 0, "R1 flags/count", xfer_left, 0);
        rst = 1'b0;
        @(negedge clk);

        // R5: stray DACK while empty is ignored
        dma_dack = 1'b1;
        @(negedge clk);
        dma_dack = 1'b0;
        @(negedge clk);
        chk(!host_full && !dma_dreq, "R5 stray dack", host_full, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            done_cnt = 0;
            dreq_rises = 0;
            pulse_start(V_LEN[v]);
            chk(busy && xfer_left == CW'(V_LEN[v]), "R4 load", xfer_left, V_LEN[v]);
            fork
                target_send(V_LEN[v], V_HOLD[v], V_BASE[v]);
                dma_take(V_LEN[v], V_DMAW[v], V_BASE[v]);
            join
            wait_done();
            chk(xfer_left == 0, "R4 counted down", xfer_left, 0);
            chk(dreq_rises == V_LEN[v], "R7 dreq count", dreq_rises, V_LEN[v]);
            chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
            chk(!busy && !scsi_ack_out, "R3 idle after (slow REQ case too)", busy, 0);
        end

        // R9 zero length
        done_cnt = 0;
        dreq_rises = 0;
        @(negedge clk);
        xfer_len = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !func_done, "R9 one edge after start", func_done, 0);
        @(negedge clk);
        chk(func_done && !busy, "R9 done two edges after start", func_done, 1);
        repeat (2) @(negedge clk);
        chk(done_cnt == 1 && dreq_rises == 0 && !scsi_ack_out, "R9 no handshake", dreq_rises, 0);

        // R6 / R10 / R8: double buffering with DMA withheld, 3 bytes
        done_cnt = 0;
        pulse_start(3);
        target_send(2, 0, 90);
        repeat (4) @(negedge clk);
        chk(host_full && stage_full, "R6 both full", {host_full, stage_full}, 3);
        @(negedge clk);
        scsi_data_in = pat(90, 2);
        scsi_req_in = 1'b1;
        repeat (10) @(negedge clk);
        chk(!scsi_ack_out, "R6 no ack while both full", scsi_ack_out, 0);
        chk(xfer_left == 1, "R4 left after two", xfer_left, 1);
        xfer_len = CW'(99);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(xfer_left == 1, "R10 start ignored when busy", xfer_left, 1);
        chk(dma_data == pat(90, 0), "R2 first byte held", dma_data, pat(90, 0));
        dma_dack = 1'b1;
        @(negedge clk);
        dma_dack = 1'b0;
        wait_ack(1'b1);
        chk(scsi_ack_out && xfer_left == 0, "R4 third byte accepted", xfer_left, 0);
        scsi_req_in = 1'b0;
        wait_ack(1'b0);
        repeat (4) @(negedge clk);
        chk(dma_data == pat(90, 1), "R2 second byte", dma_data, pat(90, 1));
        dma_dack = 1'b1;
        @(negedge clk);
        dma_dack = 1'b0;
        repeat (4) @(negedge clk);
        chk(host_full && busy && done_cnt == 0, "R8 waits for last byte", done_cnt, 0);
        chk(dma_data == pat(90, 2), "R2 last byte", dma_data, pat(90, 2));
        dma_dack = 1'b1;
        @(negedge clk);
        dma_dack = 1'b0;
        repeat (3) @(negedge clk);
        chk(done_cnt == 1 && !busy, "R8 done after last dack", done_cnt, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule